// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a processor-side write port and the embedded program/erase controller of a flash array. Every bus write arrives as one cycle of `wr_valid_i` with an address and a data byte. The decoder follows the multi-write, unlock-guarded command protocol and holds the current read mode (normal, autoselect or unlock-bypass). When a command completes, it raises a one-cycle start strobe toward the controller. Program strobes carry the captured address and data on `cmd_addr_o`/`cmd_data_o`.

Block erase is collected over a selection window. Each block write reloads a timer of `WIN_CYC` clock cycles. When the timer runs out with no new block, `erase_go_o` tells the controller to start. The controller reports `busy_i` and `error_i` back. Those two inputs decide which writes the decoder honours while an operation runs or after it has failed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Command matching compares only address bits 10:0 against 555h and 2AAh. Higher address bits have no effect on matching.
- R2: The writes AA@555h, 55@2AAh, 90@555h set `mode_o` to 1 (autoselect). `mode_o` encodes 0 = read, 1 = autoselect, 2 = unlock-bypass.
- R3: The writes AA@555h, 55@2AAh, A0@555h followed by any write pulse `prog_o` for one cycle, the cycle after that last write. `cmd_addr_o`/`cmd_data_o` then hold that write's address and data, and `mode_o` returns to 0.
- R4: The writes AA@555h, 55@2AAh, 80@555h, AA@555h, 55@2AAh, 10@555h pulse `chip_erase_o`.
- R5: The same five lead-in writes followed by 30 at any address pulse `blk_add_o` and open `window_o`. Each further 30 while the window is open pulses `blk_add_o` and restarts the window. `erase_go_o` pulses exactly `WIN_CYC` cycles after the last `blk_add_o`, and the window closes.
- R6: A single F0 write at any address, or the unlock pair followed by F0, pulses `reset_o` and sets `mode_o` to 0. A write that breaks a sequence sets `mode_o` to 0 and pulses nothing.
- R7: Unlock pair plus 20@555h sets `mode_o` to 2. In that mode, A0 followed by any write pulses `prog_o` and stays in mode 2. 90 followed by 00 returns to mode 0. Any other write is ignored.
- R8: While `busy_i` is high after a program or chip erase start, every write is ignored: no strobe, and mode and suspend state stay unchanged.
- R9: While `busy_i` is high after a block erase start, B0 pulses `suspend_o` and sets `suspended_o`, F0 pulses `reset_o`, and any other write is ignored.
- R10: B0 written while the window is open pulses `suspend_o` in the next cycle and closes the window. `erase_go_o` never fires for that window, and later 30 writes do not add blocks.
- R11: A single 30 write at any address while `suspended_o` is high and `busy_i` is low pulses `resume_o` and clears `suspended_o`.
- R12: While `error_i` is high, only reset is honoured. In unlock-bypass mode a single F0 write pulses `reset_o` and `mode_o` stays 2.
- R13: At most one strobe is raised per cycle. Each accepted command gives exactly one strobe, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | One bus write this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| busy_i | input | 1 | Controller running an operation |
| error_i | input | 1 | Controller reported a failure |
| mode_o | output | 2 | 0 read, 1 autoselect, 2 unlock-bypass |
| suspended_o | output | 1 | Erase currently suspended |
| window_o | output | 1 | Block selection window open |
| prog_o | output | 1 | Start program strobe |
| chip_erase_o | output | 1 | Start chip erase strobe |
| blk_add_o | output | 1 | Add block to erase list strobe |
| erase_go_o | output | 1 | Selection window expired, start block erase |
| suspend_o | output | 1 | Suspend erase strobe |
| resume_o | output | 1 | Resume erase strobe |
| reset_o | output | 1 | Reset/abort strobe |
| cmd_addr_o | output | ADDR_W | Address captured with prog_o / blk_add_o |
| cmd_data_o | output | 8 | Data captured with prog_o / blk_add_o |

## Verification
The sequences are driven with upper address bits set, so a decoder that compares the full address breaks visibly. A single low-bit address change then shows that the lower bits are still compared. Several block additions are spaced less than one window apart, and the gap to `erase_go_o` is counted cycle by cycle to catch off-by-one reloads. Suspend is exercised both inside the open window and during a busy block erase, which separates the two suspend paths and the resume that follows each. Error and busy stimuli reuse otherwise valid sequences, so every strobe that appears there is known to be wrongly accepted.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_W = 11;
  localparam logic [CMD_W-1:0] ADR_A = 11'h555;
  localparam logic [CMD_W-1:0] ADR_B = 11'h2AA;

  localparam logic [7:0] D_UNLK1 = 8'hAA;
  localparam logic [7:0] D_UNLK2 = 8'h55;
  localparam logic [7:0] D_AUTO  = 8'h90;
  localparam logic [7:0] D_PROG  = 8'hA0;
  localparam logic [7:0] D_BYP   = 8'h20;
  localparam logic [7:0] D_ERASE = 8'h80;
  localparam logic [7:0] D_CHIP  = 8'h10;
  localparam logic [7:0] D_GO    = 8'h30;
  localparam logic [7:0] D_RST   = 8'hF0;
  localparam logic [7:0] D_SUSP  = 8'hB0;
  localparam logic [7:0] D_BEXIT = 8'h00;

  typedef enum logic [1:0] {M_READ = 2'd0, M_AUTO = 2'd1, M_BYP = 2'd2} mode_e;
  typedef enum logic [1:0] {K_NONE, K_PROG, K_CHIP, K_BLK} kind_e;
  typedef enum logic [2:0] {
    EV_NONE, EV_PROG, EV_CHIP, EV_ADD, EV_SUSP, EV_RESUME, EV_RST
  } ev_e;
  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3, S_BP_PGM, S_BP_EXIT
  } st_e;
endpackage

// File: rtl/fcd_window.sv
module fcd_window #(
  parameter int WIN_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic add_i,
  input  logic close_i,
  output logic open_o,
  output logic expire_o,
  output logic go_o
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic          open_q;
  logic [CW-1:0] cnt_q;

  assign expire_o = open_q && (cnt_q == CW'(1)) && !add_i && !close_i;
  assign open_o   = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      go_o   <= 1'b0;
    end else begin
      go_o <= expire_o;
      if (add_i) begin
        open_q <= 1'b1;
        cnt_q  <= CW'(WIN_CYC);
      end else if (close_i) begin
        open_q <= 1'b0;
      end else if (open_q) begin
        if (cnt_q == CW'(1)) open_q <= 1'b0;
        else cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  p_go_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(open_q) && !open_q);
  p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> (cnt_q != '0) && (cnt_q <= CW'(WIN_CYC)));
  p_close_no_go_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> !go_o && !open_q);
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              busy_i,
  input  logic              error_i,
  input  logic              win_open_i,
  input  logic              win_expire_i,
  output logic              add_o,
  output logic              close_o,
  output mode_e             mode_o,
  output logic              susp_o,
  output ev_e               ev_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [7:0]        cmd_data_o
);
  st_e   st_q, st_d;
  mode_e mode_q, mode_d;
  kind_e kind_q, kind_d;
  ev_e   ev_q, ev_d;
  logic  susp_q, susp_d;
  logic  at_a, at_b;
  logic [7:0] d;

  assign d    = wr_data_i;
  assign at_a = wr_addr_i[CMD_W-1:0] == ADR_A;  // upper bits ignored
  assign at_b = wr_addr_i[CMD_W-1:0] == ADR_B;

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    kind_d  = kind_q;
    susp_d  = susp_q;
    ev_d    = EV_NONE;
    add_o   = 1'b0;
    close_o = 1'b0;
    if (win_expire_i) kind_d = K_BLK;
    if (wr_valid_i) begin
      if (win_open_i) begin
        if (d == D_SUSP && !error_i) begin
          ev_d = EV_SUSP; close_o = 1'b1; susp_d = 1'b1; kind_d = K_BLK;
        end else if (d == D_RST) begin
          ev_d = EV_RST; close_o = 1'b1;
        end else if (d == D_GO && !error_i) begin
          ev_d = EV_ADD; add_o = 1'b1;
        end
      end else if (busy_i) begin
        if (kind_q == K_BLK) begin
          if (d == D_SUSP && !error_i) begin
            ev_d = EV_SUSP; susp_d = 1'b1;
          end else if (d == D_RST) begin
            ev_d = EV_RST;
          end
        end
      end else begin
        st_d = S_IDLE;
        unique case (st_q)
          S_IDLE: begin
            if (mode_q == M_BYP) begin
              if (d == D_PROG) st_d = S_BP_PGM;
              else if (d == D_AUTO) st_d = S_BP_EXIT;
              else if (d == D_RST && error_i) ev_d = EV_RST;
            end else if (d == D_RST) begin
              ev_d = EV_RST; mode_d = M_READ;
            end else if (d == D_GO && susp_q) begin
              if (!error_i) begin
                ev_d = EV_RESUME; susp_d = 1'b0; kind_d = K_BLK;
              end
            end else if (d == D_UNLK1 && at_a) begin
              st_d = S_U1;
            end else begin
              mode_d = M_READ;
            end
          end
          S_U1, S_E2: begin
            if (d == D_UNLK2 && at_b) st_d = (st_q == S_U1) ? S_U2 : S_E3;
            else mode_d = M_READ;
          end
          S_E1: begin
            if (d == D_UNLK1 && at_a) st_d = S_E2;
            else mode_d = M_READ;
          end
          S_U2: begin
            if (d == D_RST) begin
              ev_d = EV_RST; mode_d = M_READ;
            end else if (at_a && d == D_AUTO) begin
              if (!error_i) mode_d = M_AUTO;
            end else if (at_a && d == D_PROG) begin
              st_d = S_PGM;
            end else if (at_a && d == D_BYP && !susp_q) begin
              if (!error_i) mode_d = M_BYP;
            end else if (at_a && d == D_ERASE && !susp_q) begin
              st_d = S_E1;
            end else begin
              mode_d = M_READ;
            end
          end
          S_PGM: begin
            if (!error_i) begin
              ev_d = EV_PROG; kind_d = K_PROG; mode_d = M_READ;
            end
          end
          S_E3: begin
            if (at_a && d == D_CHIP) begin
              if (!error_i) begin
                ev_d = EV_CHIP; kind_d = K_CHIP; mode_d = M_READ;
              end
            end else if (d == D_GO) begin
              if (!error_i) begin
                ev_d = EV_ADD; add_o = 1'b1; mode_d = M_READ;
              end
            end else begin
              mode_d = M_READ;
            end
          end
          S_BP_PGM: begin
            if (!error_i) begin
              ev_d = EV_PROG; kind_d = K_PROG;
            end
          end
          S_BP_EXIT: begin
            if (d == D_BEXIT && !error_i) mode_d = M_READ;
          end
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      mode_q     <= M_READ;
      kind_q     <= K_NONE;
      susp_q     <= 1'b0;
      ev_q       <= EV_NONE;
      cmd_addr_o <= '0;
      cmd_data_o <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      kind_q <= kind_d;
      susp_q <= susp_d;
      ev_q   <= ev_d;
      if (ev_d != EV_NONE) begin
        cmd_addr_o <= wr_addr_i;
        cmd_data_o <= wr_data_i;
      end
    end
  end

  assign mode_o = mode_q;
  assign susp_o = susp_q;
  assign ev_o   = ev_q;

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && busy_i && !win_open_i && kind_q != K_BLK)
      |=> (ev_q == EV_NONE) && $stable(mode_q) && $stable(susp_q));
  p_blk_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && busy_i && !win_open_i) |=> (ev_q inside {EV_NONE, EV_SUSP, EV_RST}));
  p_err_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && error_i) |=> (ev_q inside {EV_NONE, EV_RST}));
  p_resume_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_q == EV_RESUME) |-> !susp_q && $past(susp_q));
  p_susp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_q == EV_SUSP) |-> susp_q);
  p_no_wr_no_ev_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> (ev_q == EV_NONE));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int WIN_CYC = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              busy_i,
  input  logic              error_i,
  output logic [1:0]        mode_o,
  output logic              suspended_o,
  output logic              window_o,
  output logic              prog_o,
  output logic              chip_erase_o,
  output logic              blk_add_o,
  output logic              erase_go_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic              reset_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [7:0]        cmd_data_o
);
  logic  add, close, win_open, win_expire;
  mode_e mode;
  ev_e   ev;

  fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni, .wr_valid_i, .wr_addr_i, .wr_data_i, .busy_i, .error_i,
    .win_open_i  (win_open),
    .win_expire_i(win_expire),
    .add_o       (add),
    .close_o     (close),
    .mode_o      (mode),
    .susp_o      (suspended_o),
    .ev_o        (ev),
    .cmd_addr_o, .cmd_data_o
  );

  fcd_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i, .rst_ni,
    .add_i   (add),
    .close_i (close),
    .open_o  (win_open),
    .expire_o(win_expire),
    .go_o    (erase_go_o)
  );

  assign mode_o       = mode;
  assign window_o     = win_open;
  assign prog_o       = ev == EV_PROG;
  assign chip_erase_o = ev == EV_CHIP;
  assign blk_add_o    = ev == EV_ADD;
  assign suspend_o    = ev == EV_SUSP;
  assign resume_o     = ev == EV_RESUME;
  assign reset_o      = ev == EV_RST;

  p_one_strobe_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_o, chip_erase_o, blk_add_o, erase_go_o, suspend_o, resume_o, reset_o}));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int AW  = 19;
  localparam int WIN = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic wv = 0, bz = 0, er = 0;
  logic [AW-1:0] wa = '0;
  logic [7:0] wd = '0;
  logic [1:0] mode_o;
  logic susp_o, win_o, prog_o, chip_o, add_o, go_o, sus_o, res_o, rst_o;
  logic [AW-1:0] caddr;
  logic [7:0] cdata;

  flash_cmd_decoder #(.ADDR_W(AW), .WIN_CYC(WIN)) i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_addr_i(wa), .wr_data_i(wd),
    .busy_i(bz), .error_i(er), .mode_o(mode_o), .suspended_o(susp_o), .window_o(win_o),
    .prog_o(prog_o), .chip_erase_o(chip_o), .blk_add_o(add_o), .erase_go_o(go_o),
    .suspend_o(sus_o), .resume_o(res_o), .reset_o(rst_o), .cmd_addr_o(caddr),
    .cmd_data_o(cdata)
  );

  int n_chk = 0, n_fail = 0;
  string tag = "R6";
  bit done = 0;

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mode, m_kind, m_cnt;
  bit m_susp, m_win;
  int qd[$], qa[$];
  bit e_prog, e_chip, e_add, e_go, e_sus, e_res, e_rst;
  logic [AW-1:0] e_addr;
  logic [7:0] e_data;
  localparam int BLK = 3, PRG = 1, CHP = 2;

  task automatic strobe_addr(input logic [AW-1:0] a, input logic [7:0] dd);
    e_addr = a; e_data = dd;
  endtask

  task automatic seq_step(input logic [AW-1:0] a, input int d, input bit err);
    int n, lo;
    lo = int'(a[10:0]);
    qd.push_back(d); qa.push_back(lo);
    n = qd.size();
    if (m_mode == 2) begin
      if (n == 1 && (d == 'hA0 || d == 'h90)) return;
      if (n == 1 && d == 'hF0 && err) e_rst = 1;
      if (n == 2 && qd[0] == 'hA0 && !err) begin e_prog = 1; m_kind = PRG; strobe_addr(a, d[7:0]); end
      if (n == 2 && qd[0] == 'h90 && d == 0 && !err) m_mode = 0;
      qd.delete(); qa.delete();
      return;
    end
    case (n)
      1: begin
        if (d == 'hF0) begin e_rst = 1; m_mode = 0; end
        else if (d == 'h30 && m_susp) begin
          if (!err) begin e_res = 1; m_susp = 0; m_kind = BLK; end
        end else if (d == 'hAA && lo == 'h555) return;
        else m_mode = 0;
      end
      2, 5: if (d == 'h55 && lo == 'h2AA) return; else m_mode = 0;
      3: begin
        if (d == 'hF0) begin e_rst = 1; m_mode = 0; end
        else if (lo == 'h555 && d == 'h90) begin if (!err) m_mode = 1; end
        else if (lo == 'h555 && d == 'hA0) return;
        else if (lo == 'h555 && d == 'h20 && !m_susp) begin if (!err) m_mode = 2; end
        else if (lo == 'h555 && d == 'h80 && !m_susp) return;
        else m_mode = 0;
      end
      4: begin
        if (qd[2] == 'hA0) begin
          if (!err) begin e_prog = 1; m_kind = PRG; m_mode = 0; strobe_addr(a, d[7:0]); end
        end else if (d == 'hAA && lo == 'h555) return;
        else m_mode = 0;
      end
      default: begin
        if (lo == 'h555 && d == 'h10) begin
          if (!err) begin e_chip = 1; m_kind = CHP; m_mode = 0; end
        end else if (d == 'h30) begin
          if (!err) begin e_add = 1; m_win = 1; m_cnt = WIN; m_mode = 0; strobe_addr(a, d[7:0]); end
        end else m_mode = 0;
      end
    endcase
    qd.delete(); qa.delete();
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_kind = 0; m_cnt = 0; m_susp = 0; m_win = 0;
      qd.delete(); qa.delete();
      {e_prog, e_chip, e_add, e_go, e_sus, e_res, e_rst} = '0;
      e_addr = '0; e_data = '0;
    end else begin
      {e_prog, e_chip, e_add, e_go, e_sus, e_res, e_rst} = '0;
      if (m_win) begin
        if (wv && wd == 8'hB0 && !er) begin m_win = 0; m_susp = 1; m_kind = BLK; e_sus = 1; end
        else if (wv && wd == 8'hF0) begin m_win = 0; e_rst = 1; end
        else if (wv && wd == 8'h30 && !er) begin e_add = 1; m_cnt = WIN; strobe_addr(wa, wd); end
        else if (m_cnt == 1) begin m_win = 0; e_go = 1; m_kind = BLK; end
        else m_cnt--;
      end else if (wv && bz) begin
        if (m_kind == BLK) begin
          if (wd == 8'hB0 && !er) begin e_sus = 1; m_susp = 1; end
          else if (wd == 8'hF0) e_rst = 1;
        end
      end else if (wv) seq_step(wa, int'(wd), er);
    end
  end

  // compared every clock, one check per cycle (R13 covered by strobe vector)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [11:0] act, exp;
      act = {mode_o, susp_o, win_o, prog_o, chip_o, add_o, go_o, sus_o, res_o, rst_o, 1'b0};
      exp = {m_mode[1:0], m_susp, m_win, e_prog, e_chip, e_add, e_go, e_sus, e_res, e_rst, 1'b0};
      chk(act == exp, {tag, " model"}, 32'(act), 32'(exp));
      if (e_prog || e_add)
        chk(caddr == e_addr && cdata == e_data, {tag, " cmd"}, {5'd0, caddr, cdata}, {5'd0, e_addr, e_data});
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wv = 1; wa = a; wd = d;
    @(negedge clk);
    wv = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic unlock(input logic [AW-1:0] hi);
    wr(hi | 19'h555, 8'hAA);
    wr(hi | 19'h2AA, 8'h55);
  endtask
  task automatic blk_erase(input logic [AW-1:0] ba);
    unlock(19'h0); wr(19'h555, 8'h80); unlock(19'h0); wr(ba, 8'h30);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    tag = "R6";
    chk(mode_o == 0 && !win_o && !susp_o, "R6 reset state", {mode_o, win_o, susp_o}, 0);

    tag = "R1"; // upper address bits set, unlock still matches
    unlock(19'h7C000); wr(19'h7C555, 8'h90);
    tag = "R2";
    chk(mode_o == 1, "R2 autoselect", mode_o, 1);
    tag = "R1";
    wr(19'h00455, 8'hAA);
    chk(mode_o == 0, "R1 low bits compared", mode_o, 0);

    tag = "R3";
    unlock(19'h40000); wr(19'h555, 8'hA0); wr(19'h12345, 8'h5A);
    chk(prog_o && caddr == 19'h12345 && cdata == 8'h5A, "R3 program", {prog_o, caddr}, {1'b1, 19'h12345});
    idle(1);
    chk(!prog_o, "R13 single pulse", prog_o, 0);

    tag = "R6";
    unlock(19'h0); wr(19'h555, 8'h90);
    wr(19'h3, 8'hF0);
    chk(rst_o && mode_o == 0, "R6 single reset", {rst_o, mode_o}, 3'b100);
    unlock(19'h0); wr(19'h777, 8'hF0);
    chk(rst_o, "R6 unlock reset", rst_o, 1);
    unlock(19'h0); wr(19'h555, 8'h77);
    chk(mode_o == 0 && !rst_o, "R6 invalid", {rst_o, mode_o}, 0);

    tag = "R4";
    unlock(19'h0); wr(19'h555, 8'h80); unlock(19'h0); wr(19'h555, 8'h10);
    chk(chip_o, "R4 chip erase", chip_o, 1);
    tag = "R8";
    bz = 1; idle(1);
    unlock(19'h0); wr(19'h555, 8'h90); wr(19'h0, 8'hB0); wr(19'h0, 8'hF0);
    chk(!rst_o && !sus_o && mode_o == 0, "R8 busy ignore", {rst_o, sus_o, mode_o}, 0);
    bz = 0; idle(2);

    tag = "R5";
    blk_erase(19'h10000);
    chk(add_o && win_o && caddr == 19'h10000, "R5 first block", {add_o, win_o}, 2'b11);
    idle(5); wr(19'h20000, 8'h30); idle(8); wr(19'h50000, 8'h30);
    begin
      int n;
      n = 0;
      while (!go_o && n < 40) begin @(negedge clk); n++; end
      chk(n == WIN, "R5 window length", n, WIN);
    end
    tag = "R9";
    bz = 1; idle(1);
    wr(19'h0, 8'h55);
    chk(!sus_o && !rst_o, "R9 other ignored", {sus_o, rst_o}, 0);
    wr(19'h0, 8'hB0);
    chk(sus_o && susp_o, "R9 suspend", {sus_o, susp_o}, 2'b11);
    bz = 0; idle(1);
    unlock(19'h0); wr(19'h555, 8'hA0); wr(19'h60001, 8'h11);
    chk(prog_o, "R9 program while suspended", prog_o, 1);
    bz = 1; idle(3); bz = 0; idle(1);
    tag = "R11";
    wr(19'h6AB, 8'h30);
    chk(res_o && !susp_o, "R11 resume", {res_o, susp_o}, 2'b10);
    tag = "R9";
    bz = 1; idle(1);
    wr(19'h1, 8'hF0);
    chk(rst_o, "R9 reset during erase", rst_o, 1);
    bz = 0; idle(2);

    tag = "R10";
    blk_erase(19'h30000); idle(3);
    wr(19'h0, 8'hB0);
    chk(sus_o && !win_o, "R10 window suspend", {sus_o, win_o}, 2'b10);
    wr(19'h40000, 8'h30);
    chk(res_o && !add_o, "R10 no add after resume", {res_o, add_o}, 2'b10);
    idle(WIN + 3);
    chk(!go_o && !win_o, "R10 no go", {go_o, win_o}, 0);

    tag = "R7";
    unlock(19'h0); wr(19'h555, 8'h20);
    chk(mode_o == 2, "R7 bypass entry", mode_o, 2);
    wr(19'h0, 8'hA0); wr(19'h7000F, 8'hC3);
    chk(prog_o && mode_o == 2 && cdata == 8'hC3, "R7 bypass program", {prog_o, mode_o}, 3'b110);
    wr(19'h555, 8'hAA); wr(19'h0, 8'hF0);
    chk(mode_o == 2 && !rst_o, "R7 ignored", {rst_o, mode_o}, 3'b010);

    tag = "R12";
    er = 1;
    wr(19'h0, 8'hF0);
    chk(rst_o && mode_o == 2, "R12 reset in bypass", {rst_o, mode_o}, 3'b110);
    wr(19'h0, 8'hA0); wr(19'h100, 8'h01);
    chk(!prog_o, "R12 program blocked", prog_o, 0);
    er = 0;
    tag = "R7";
    wr(19'h0, 8'h90); wr(19'h0, 8'h00);
    chk(mode_o == 0, "R7 bypass exit", mode_o, 0);
    tag = "R12";
    er = 1;
    unlock(19'h0); wr(19'h555, 8'h90);
    chk(mode_o == 0, "R12 autoselect blocked", mode_o, 0);
    unlock(19'h0); wr(19'h555, 8'h80); unlock(19'h0); wr(19'h555, 8'h10);
    chk(!chip_o, "R12 erase blocked", chip_o, 0);
    wr(19'h0, 8'hF0);
    chk(rst_o, "R12 reset honoured", rst_o, 1);
    er = 0; idle(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule